// File: doc/BRIEF.md
# Timestamp Counter with Coupled Offset Register

This block keeps a free-running timestamp counter and a companion offset register, both 64 bits wide. Software reaches the two through a small register port with an address, write data, a write strobe, a read strobe and combinational read data. The counter advances by one on every clock unless it is being written.

The two registers are coupled. When software writes a new counter value, the offset register moves by the same signed amount the counter moved. When software writes a new offset, the counter moves by the same signed amount the offset moved. Software can therefore bring counters on separate cores into line by writing only the offset. A constant feature word carries a single set bit that tells software the offset register is present.

Top module: `stamp_counter_pair`

## Requirements
- R1: While reset (`rst_n` low) is sampled on a clock edge, the counter and the offset both become zero. Writes presented during reset have no effect.
- R2: In a cycle with no write to a mapped address, the counter advances by one at the clock edge. It wraps from all ones to zero.
- R3: A write at address 0x10 sets the counter to the write data at the clock edge. In the same edge the offset becomes old offset + (write data − old counter), modulo 2^64.
- R4: A write at address 0x3B sets the offset to the write data at the clock edge. In the same edge the counter becomes old counter + (write data − old offset) + 1, modulo 2^64.
- R5: With `reg_rd` high, `reg_rdata` shows the present counter at address 0x10 and the present offset at address 0x3B, in the same cycle and without a clock edge.
- R6: A read at any other address returns zero. A write at any other address leaves the offset unchanged and lets the counter advance as in R2. With `reg_rd` low, `reg_rdata` is zero.
- R7: `feature_word` has bit 1 set and every other bit clear.
- R8: Across a counter write, (counter − offset) keeps its value. Across every other cycle out of reset, (counter − offset) grows by exactly one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| reg_addr | input | ADDR_W (10) | Register address |
| reg_wdata | input | CNT_W (64) | Write data |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_rd | input | 1 | Read strobe |
| reg_rdata | output | CNT_W (64) | Combinational read data |
| feature_word | output | FEAT_W (32) | Capability word, bit 1 means the offset register is present |

## Verification
The bench writes counter and offset values with every single bit set and every single bit cleared. These values include the all-ones and the top-bit boundaries, where a design that does not take the difference modulo 2^64, or that drops the carry, would leave the partner register off. It runs the counter through its wrap point and checks for the extra tick that must follow an offset write. A design that loses or duplicates that increment would shift the counter by one, and the counter−offset gap check would catch it. It then writes and reads every unmapped address, which would expose a decoder that aliases address bits or a read path that returns stale data.

// File: rtl/stamp_pkg.sv
// Package: shared selection type and default register addresses for the
// timestamp counter pair. Assumes address values fit the chosen address width.
package stamp_pkg;
    typedef enum logic [1:0] {
        SEL_NONE  = 2'd0,
        SEL_STAMP = 2'd1,
        SEL_OFFS  = 2'd2
    } stamp_sel_e;

    localparam int unsigned DEF_STAMP_ADDR = 32'h10;
    localparam int unsigned DEF_OFFS_ADDR  = 32'h3B;
endpackage

// File: rtl/stamp_decode.sv
// Module: stamp_decode
// Turns the register port address and strobes into one-hot write selects and
// a read selector. Assumes the two register addresses differ.
module stamp_decode
    import stamp_pkg::*;
#(
    parameter int unsigned ADDR_W     = 10,
    parameter int unsigned STAMP_ADDR = DEF_STAMP_ADDR,
    parameter int unsigned OFFS_ADDR  = DEF_OFFS_ADDR
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic              wr_stamp,
    output logic              wr_offs,
    output stamp_sel_e        rd_sel
);
    localparam logic [ADDR_W-1:0] STAMP_A = ADDR_W'(STAMP_ADDR);
    localparam logic [ADDR_W-1:0] OFFS_A  = ADDR_W'(OFFS_ADDR);

    stamp_sel_e hit;

    // Match the address against the two mapped registers.
    always_comb begin
        if (addr == STAMP_A)      hit = SEL_STAMP;
        else if (addr == OFFS_A)  hit = SEL_OFFS;
        else                      hit = SEL_NONE;
    end

    // Qualify the match with the strobes.
    always_comb begin
        wr_stamp = wr && (hit == SEL_STAMP);
        wr_offs  = wr && (hit == SEL_OFFS);
        rd_sel   = rd ? hit : SEL_NONE;
    end
endmodule

// File: rtl/stamp_delta.sv
// Module: stamp_delta
// Computes the signed differences between the write data and each register.
// Two's complement subtraction modulo 2^CNT_W serves for either sign.
module stamp_delta #(
    parameter int unsigned CNT_W = 64
) (
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] cnt_q,
    input  logic [CNT_W-1:0] adj_q,
    output logic [CNT_W-1:0] cnt_delta,
    output logic [CNT_W-1:0] adj_delta
);
    // Difference a write would apply to each register.
    always_comb begin
        cnt_delta = wdata - cnt_q;
        adj_delta = wdata - adj_q;
    end
endmodule

// File: rtl/stamp_counter.sv
// Module: stamp_counter
// The free-running counter. It loads on a direct write, takes the offset delta
// plus its normal tick on an offset write, and otherwise increments.
// Assumes at most one of the write selects is high.
module stamp_counter #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stamp,
    input  logic             wr_offs,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] adj_delta,
    output logic [CNT_W-1:0] cnt_q
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_d;

    // Select the next counter value.
    always_comb begin
        if (wr_stamp)      cnt_d = wdata;
        else if (wr_offs)  cnt_d = cnt_q + adj_delta + ONE;
        else               cnt_d = cnt_q + ONE;
    end

    // Counter register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/stamp_offset.sv
// Module: stamp_offset
// The offset register. It loads on a direct write, follows the counter delta
// on a counter write, and otherwise holds.
// Assumes at most one of the write selects is high.
module stamp_offset #(
    parameter int unsigned CNT_W = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_stamp,
    input  logic             wr_offs,
    input  logic [CNT_W-1:0] wdata,
    input  logic [CNT_W-1:0] cnt_delta,
    output logic [CNT_W-1:0] adj_q
);
    logic [CNT_W-1:0] adj_d;

    // Select the next offset value.
    always_comb begin
        if (wr_offs)        adj_d = wdata;
        else if (wr_stamp)  adj_d = adj_q + cnt_delta;
        else                adj_d = adj_q;
    end

    // Offset register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) adj_q <= '0;
        else        adj_q <= adj_d;
    end
endmodule

// File: rtl/stamp_counter_pair.sv
// Module: stamp_counter_pair (top)
// Timestamp counter and offset register coupled by write deltas, with a
// register port and a constant capability word.
// Assumes a single address per cycle, so only one write can occur.
module stamp_counter_pair
    import stamp_pkg::*;
#(
    parameter int unsigned CNT_W      = 64,
    parameter int unsigned ADDR_W     = 10,
    parameter int unsigned FEAT_W     = 32,
    parameter int unsigned FEAT_BIT   = 1,
    parameter int unsigned STAMP_ADDR = DEF_STAMP_ADDR,
    parameter int unsigned OFFS_ADDR  = DEF_OFFS_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [CNT_W-1:0]  reg_wdata,
    input  logic              reg_wr,
    input  logic              reg_rd,
    output logic [CNT_W-1:0]  reg_rdata,
    output logic [FEAT_W-1:0] feature_word
);
    logic             wr_stamp;
    logic             wr_offs;
    stamp_sel_e       rd_sel;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] adj_q;
    logic [CNT_W-1:0] cnt_delta;
    logic [CNT_W-1:0] adj_delta;

    stamp_decode #(
        .ADDR_W(ADDR_W), .STAMP_ADDR(STAMP_ADDR), .OFFS_ADDR(OFFS_ADDR)
    ) u_decode (
        .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
        .wr_stamp(wr_stamp), .wr_offs(wr_offs), .rd_sel(rd_sel)
    );

    stamp_delta #(.CNT_W(CNT_W)) u_delta (
        .wdata(reg_wdata), .cnt_q(cnt_q), .adj_q(adj_q),
        .cnt_delta(cnt_delta), .adj_delta(adj_delta)
    );

    stamp_counter #(.CNT_W(CNT_W)) u_counter (
        .clk(clk), .rst_n(rst_n), .wr_stamp(wr_stamp), .wr_offs(wr_offs),
        .wdata(reg_wdata), .adj_delta(adj_delta), .cnt_q(cnt_q)
    );

    stamp_offset #(.CNT_W(CNT_W)) u_offset (
        .clk(clk), .rst_n(rst_n), .wr_stamp(wr_stamp), .wr_offs(wr_offs),
        .wdata(reg_wdata), .cnt_delta(cnt_delta), .adj_q(adj_q)
    );

    // Combinational read multiplexer; unmapped or idle reads give zero.
    always_comb begin
        case (rd_sel)
            SEL_STAMP: reg_rdata = cnt_q;
            SEL_OFFS:  reg_rdata = adj_q;
            default:   reg_rdata = '0;
        endcase
    end

    // Capability word: one set bit at FEAT_BIT.
    for (genvar b = 0; b < FEAT_W; b++) begin : g_feat
        assign feature_word[b] = (b == FEAT_BIT);
    end
endmodule

// File: rtl/stamp_counter_pair_chk.sv
// Module: stamp_counter_pair_chk
// Property checker for the coupled counter pair, bound into the top module.
module stamp_counter_pair_chk #(
    parameter int unsigned CNT_W      = 64,
    parameter int unsigned ADDR_W     = 10,
    parameter int unsigned STAMP_ADDR = 32'h10,
    parameter int unsigned OFFS_ADDR  = 32'h3B
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [CNT_W-1:0]  reg_wdata,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [CNT_W-1:0]  reg_rdata,
    input logic [CNT_W-1:0]  cnt_q,
    input logic [CNT_W-1:0]  adj_q
);
    localparam logic [ADDR_W-1:0] SA = ADDR_W'(STAMP_ADDR);
    localparam logic [ADDR_W-1:0] OA = ADDR_W'(OFFS_ADDR);
    localparam logic [CNT_W-1:0]  ONE = CNT_W'(1);

    logic s_wr, o_wr;
    assign s_wr = reg_wr && (reg_addr == SA);
    assign o_wr = reg_wr && (reg_addr == OA);

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> (cnt_q == '0) && (adj_q == '0)); // R1

    AST_IDLE_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!s_wr && !o_wr) |=> (cnt_q == $past(cnt_q) + ONE) && $stable(adj_q)); // R2

    AST_STAMP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        s_wr |=> (cnt_q == $past(reg_wdata))
              && (adj_q == $past(adj_q) + ($past(reg_wdata) - $past(cnt_q)))); // R3

    AST_OFFS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        o_wr |=> (adj_q == $past(reg_wdata))
              && (cnt_q == $past(cnt_q) + ($past(reg_wdata) - $past(adj_q)) + ONE)); // R4

    AST_READ_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == SA) |-> reg_rdata == cnt_q); // R5

    AST_READ_OFFS: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd && reg_addr == OA) |-> reg_rdata == adj_q); // R5

    AST_READ_UNMAPPED: assert property (@(posedge clk) disable iff (!rst_n)
        (!reg_rd || (reg_addr != SA && reg_addr != OA)) |-> reg_rdata == '0); // R6

    AST_GAP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !s_wr |=> (cnt_q - adj_q) == ($past(cnt_q) - $past(adj_q)) + ONE); // R8
endmodule

bind stamp_counter_pair stamp_counter_pair_chk #(
    .CNT_W(CNT_W), .ADDR_W(ADDR_W), .STAMP_ADDR(STAMP_ADDR), .OFFS_ADDR(OFFS_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
    .cnt_q(cnt_q), .adj_q(adj_q)
);

// File: tb/stamp_counter_pair_bench.sv
// Bench: sweeps write values over every bit position, the wrap point and every
// address, against an arithmetic model built from the requirements.
module stamp_counter_pair_bench;
    localparam int unsigned W  = 64;
    localparam int unsigned AW = 10;
    localparam logic [AW-1:0] SA = 10'h10;
    localparam logic [AW-1:0] OA = 10'h3B;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic [W-1:0]  reg_wdata = '0;
    logic          reg_wr = 1'b0;
    logic          reg_rd = 1'b0;
    logic [W-1:0]  reg_rdata;
    logic [31:0]   feature_word;

    int checks = 0;
    int fails  = 0;

    logic [W-1:0] m_cnt = '0;
    logic [W-1:0] m_adj = '0;

    always #2 clk = ~clk;

    stamp_counter_pair u_stamp_counter_pair (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_rdata(reg_rdata),
        .feature_word(feature_word)
    );

    // Reference model from R1..R4, updated at the same edge as the design.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= '0;
            m_adj <= '0;
        end else if (reg_wr && reg_addr == SA) begin
            m_adj <= m_adj + (reg_wdata - m_cnt);
            m_cnt <= reg_wdata;
        end else if (reg_wr && reg_addr == OA) begin
            m_cnt <= m_cnt + (reg_wdata - m_adj) + 64'd1;
            m_adj <= reg_wdata;
        end else begin
            m_cnt <= m_cnt + 64'd1;
        end
    end

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One cycle of write at negedge; the write lands at the next posedge.
    task automatic do_write(input logic [AW-1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1; reg_rd = 1'b0;
    endtask

    // One cycle reading address a, compared with the model.
    task automatic rd_chk(input string tag, input logic [AW-1:0] a);
        logic [W-1:0] exp;
        @(negedge clk);
        reg_addr = a; reg_wr = 1'b0; reg_rd = 1'b1; reg_wdata = '1;
        #1;
        exp = (a == SA) ? m_cnt : (a == OA) ? m_adj : '0;
        check(tag, reg_rdata, exp);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] c0, a0, c1, a1;
        // R1: writes ignored during reset, both registers read zero
        repeat (2) do_write(OA, 64'h55);
        do_write(SA, 64'h77);
        rd_chk("R1 counter in reset", SA);
        rd_chk("R1 offset in reset", OA);
        check("R1 model zero", m_cnt | m_adj, '0);
        @(negedge clk); rst_n = 1'b1; reg_rd = 1'b0; reg_wr = 1'b0;

        // R7: capability word
        check("R7 feature word", W'(feature_word), 64'h2);

        // R2/R5: free counting with same-cycle reads
        for (int i = 0; i < 16; i++) rd_chk("R5 R2 idle count", SA);
        rd_chk("R5 offset read", OA);

        // R2: wrap through all ones
        do_write(SA, 64'hFFFF_FFFF_FFFF_FFFD);
        for (int i = 0; i < 6; i++) rd_chk("R2 wrap", SA);

        // R3: counter writes with every one-hot and one-cold value
        for (int i = 0; i < 64; i++) begin
            do_write(SA, 64'd1 << i);
            rd_chk("R3 offset after counter write", OA);
            rd_chk("R3 counter after counter write", SA);
            do_write(SA, ~(64'd1 << i));
            rd_chk("R3 offset after counter write inv", OA);
        end

        // R4: offset writes with every one-hot and one-cold value
        for (int i = 0; i < 64; i++) begin
            do_write(OA, 64'd1 << i);
            rd_chk("R4 counter after offset write", SA);
            rd_chk("R4 offset after offset write", OA);
            do_write(OA, ~(64'd1 << i));
            rd_chk("R4 counter after offset write inv", SA);
        end
        do_write(OA, '1);
        do_write(OA, '0);
        rd_chk("R4 counter after back to back offset writes", SA);

        // R6: every unmapped address written and read
        for (int a = 0; a < (1 << AW); a++) begin
            if (AW'(a) != SA && AW'(a) != OA) begin
                do_write(AW'(a), {32'hDEAD_BEEF, 32'(a)});
                rd_chk("R6 unmapped read", AW'(a));
            end
        end
        rd_chk("R6 offset kept", OA);
        rd_chk("R6 counter kept", SA);
        @(negedge clk); reg_addr = SA; reg_rd = 1'b0; reg_wr = 1'b0;
        #1 check("R6 read strobe low", reg_rdata, '0);

        // R8: gap unchanged across a counter write, plus one per other cycle
        rd_chk("R8 pre counter", SA); c0 = reg_rdata;
        rd_chk("R8 pre offset", OA);  a0 = reg_rdata;
        do_write(SA, 64'h8000_0000_0000_0005);
        rd_chk("R8 post counter", SA); c1 = reg_rdata;
        rd_chk("R8 post offset", OA);  a1 = reg_rdata;
        check("R8 gap across counter write", c1 - a1, (c0 - a0) + 64'd2);
        do_write(OA, 64'h1234);
        rd_chk("R8 post offset write counter", SA); c0 = reg_rdata;
        check("R8 gap across offset write", c0 - 64'h1234, (c1 - a1) + 64'd3);

        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule